// File: doc/BRIEF.md
# Bytewise CRC-16 Engine (polynomial 0x1021, all-ones seed)

This block keeps a running 16-bit cyclic redundancy check over a frame of bytes and folds in one whole byte in every cycle where the byte strobe is high. It uses the generator polynomial 0x1021. The register is seeded with 0xFFFF. Input bytes and the result are processed most significant bit first, with no bit reflection and no final inversion. The surrounding logic pulses a start input at the beginning of each frame, feeds the frame's bytes in order from the first byte, and reads the checksum from the output one cycle after the last byte.

The same engine serves for both generating and checking a checksum. The surrounding logic owns frame buffering, length counting and any decision taken on the result. For convenience, the block also offers a combinational equality flag against a caller-supplied expected value. A parameter can remove this flag.

The update uses a nibble-shift form, which needs no loop over bits. The register is first byte-swapped and the input byte is XORed into its low half. Three shifted XOR terms then follow: the low byte shifted right by 4, the whole word shifted left by 12, and the low byte shifted left by 5.

Top module: `crc16_byte_engine`

## Requirements
- R1: While rst_n is low at a rising clock edge, the register loads 0xFFFF, so crc_o reads 0xFFFF after reset.
- R2: After start and then the nine ASCII bytes "123456789" (0x31 to 0x39, in that order), crc_o reads 0x29B1. No final XOR is applied.
- R3: Each cycle with byte_vld_i high and start_i low replaces the register with the CRC of that byte appended to the current value. This is computed MSB first with polynomial 0x1021 and no reflection. The new value appears on crc_o after that rising edge.
- R4: In a cycle with byte_vld_i and start_i both low, the register keeps its value, whatever byte_i carries.
- R5: A cycle with start_i high and byte_vld_i low reloads 0xFFFF, whatever the previous value was.
- R6: A cycle with start_i and byte_vld_i both high folds byte_i into a fresh 0xFFFF seed, discarding the previous value.
- R7: match_o is high exactly when crc_o equals expect_i. It follows expect_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new frame (reseed) |
| byte_vld_i | input | 1 | byte_i is to be folded in this cycle |
| byte_i | input | 8 | Frame byte |
| expect_i | input | 16 | Value compared against crc_o |
| crc_o | output | 16 | Running CRC register |
| match_o | output | 1 | crc_o equals expect_i |

## Verification
The bench runs the standard nine-byte check string and random frames of varied length against an independent bit-serial model. An engine with a wrong shift, a missing byte swap or a reflected bit order would diverge on the first byte. Idle cycles that carry changing garbage on byte_i would expose a register that ignores the strobe, and a start pulse landing on a dirty register would expose a reload that keeps stale state. The case where start and a byte arrive together separates an engine that folds the byte into the old value, or drops the byte, from a correct one. The match flag is probed with equal and off-by-one expected values.

// File: rtl/crc16_pkg.sv
// Package: shared widths, seed and types for the bytewise CRC-16 engine.
// Assumes MSB-first processing, polynomial 0x1021, no output inversion.
package crc16_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc16_nib_step.sv
// Module: one-byte CRC advance in nibble-shift form.
// Purely combinational; assumes a 16-bit register and an 8-bit input byte
// (the shift amounts are fixed by the 0x1021 polynomial).
module crc16_nib_step
    import crc16_pkg::*;
(
    input  crc_t  crc_i,
    input  byte_t data_i,
    output crc_t  crc_o
);
    localparam int HALF_W = CRC_W / 2;

    crc_t swp, t_in, t_r4, t_l12;

    // Byte swap, input fold, then the three shifted XOR terms.
    always_comb begin
        swp   = {crc_i[HALF_W-1:0], crc_i[CRC_W-1:HALF_W]};
        t_in  = swp ^ crc_t'(data_i);
        t_r4  = t_in ^ crc_t'(t_in[HALF_W-1:0] >> 4);
        t_l12 = t_r4 ^ (t_r4 << 12);
        crc_o = t_l12 ^ (crc_t'(t_l12[HALF_W-1:0]) << 5);
    end
endmodule

// File: rtl/crc16_state_reg.sv
// Module: CRC state register with reseed selection.
// Presents the base value for the next step (seed on start, else state) and
// captures the stepped value on a valid byte; assumes synchronous active-low reset.
module crc16_state_reg
    import crc16_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  crc_t next_i,
    output crc_t base_o,
    output crc_t crc_q
);
    // Choose the value the step logic advances from.
    always_comb base_o = start_i ? SEED : crc_q;

    // Register update: reset/start reseed, valid captures, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= SEED;
        else if (valid_i)
            crc_q <= next_i;
        else if (start_i)
            crc_q <= SEED;
    end

    assert_reset_seed_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> crc_q == SEED);

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> $stable(crc_q));

    assert_start_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) |=> crc_q == SEED);

    assert_byte_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> crc_q == $past(next_i));
endmodule

// File: rtl/crc16_match.sv
// Module: combinational equality flag between the CRC and an expected value.
// Assumes both operands are already aligned 16-bit words.
module crc16_match
    import crc16_pkg::*;
(
    input  crc_t crc_i,
    input  crc_t expect_i,
    output logic eq_o
);
    // Whole-word compare.
    always_comb eq_o = (crc_i == expect_i);
endmodule

// File: rtl/crc16_byte_engine.sv
// Module: top of the bytewise CRC-16 engine (poly 0x1021, seed 0xFFFF,
// no reflection, no final XOR). One byte is folded per strobed cycle.
// Assumes the caller pulses start_i per frame; start with a byte seeds first.
module crc16_byte_engine
    import crc16_pkg::*;
#(
    parameter crc_t SEED      = CRC_SEED,
    parameter bit   HAS_MATCH = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic [15:0] expect_i,
    output logic [15:0] crc_o,
    output logic        match_o
);
    crc_t base, next, state;

    crc16_state_reg #(.SEED(SEED)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (byte_vld_i),
        .next_i  (next),
        .base_o  (base),
        .crc_q   (state)
    );

    crc16_nib_step u_step (
        .crc_i  (base),
        .data_i (byte_i),
        .crc_o  (next)
    );

    // Drive the result port from the state register.
    always_comb crc_o = state;

    generate
        if (HAS_MATCH) begin : g_match
            crc16_match u_match (
                .crc_i    (state),
                .expect_i (expect_i),
                .eq_o     (match_o)
            );
        end else begin : g_no_match
            assign match_o = 1'b0;
        end
    endgenerate

    assert_seeded_fold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && byte_vld_i) |-> base == SEED);
endmodule

// File: tb/test_crc16_byte_engine.sv
`timescale 1ns/1ps
module test_crc16_byte_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] expect_i = 16'h0000;
    logic [15:0] crc_o;
    logic        match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crc16_byte_engine i_crc16_byte_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .expect_i(expect_i), .crc_o(crc_o), .match_o(match_o)
    );

    function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one beat at a negedge; the result is visible at the next negedge.
    task automatic beat(logic st, logic vld, logic [7:0] b);
        start_i = st; byte_vld_i = vld; byte_i = b;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset seed", crc_o, 16'hFFFF);
    endtask

    task automatic t_check_string;
        logic [15:0] m = 16'hFFFF;
        beat(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 9; i++) begin
            beat(1'b0, 1'b1, 8'h31 + 8'(i));
            m = ref_byte(m, 8'h31 + 8'(i));
        end
        chk("R2 check string", crc_o, 16'h29B1);
        chk("R3 model agrees on check string", crc_o, m);
    endtask

    task automatic t_random_frames;
        for (int f = 0; f < 20; f++) begin
            logic [15:0] m = 16'hFFFF;
            int len = 1 + (f * 7) % 40;
            beat(1'b1, 1'b0, 8'h00);
            for (int i = 0; i < len; i++) begin
                logic [7:0] b = 8'($urandom);
                start_i = 1'b0; byte_vld_i = 1'b1; byte_i = b;
                @(negedge clk);
                m = ref_byte(m, b);
                chk("R3 running value per byte", crc_o, m);
            end
            byte_vld_i = 1'b0;
        end
    endtask

    task automatic t_hold;
        logic [15:0] held;
        beat(1'b0, 1'b1, 8'hA5);
        held = crc_o;
        for (int i = 0; i < 6; i++) begin
            byte_i = 8'($urandom);
            @(negedge clk);
        end
        chk("R4 hold without strobe", crc_o, held);
    endtask

    task automatic t_start_only;
        beat(1'b0, 1'b1, 8'h3C);
        beat(1'b1, 1'b0, 8'h77);
        chk("R5 start reloads seed", crc_o, 16'hFFFF);
    endtask

    task automatic t_start_with_byte;
        beat(1'b0, 1'b1, 8'hE1);
        beat(1'b1, 1'b1, 8'h31);
        chk("R6 start plus byte", crc_o, ref_byte(16'hFFFF, 8'h31));
        beat(1'b0, 1'b1, 8'h32);
        chk("R6 frame continues after seeded byte", crc_o,
            ref_byte(ref_byte(16'hFFFF, 8'h31), 8'h32));
    endtask

    task automatic t_match;
        logic [15:0] v = crc_o;
        expect_i = v;
        #1;
        chk("R7 match equal", {15'd0, match_o}, 16'd1);
        expect_i = v + 16'd1;
        #1;
        chk("R7 match off by one", {15'd0, match_o}, 16'd0);
        expect_i = v ^ 16'h8000;
        #1;
        chk("R7 match top bit differs", {15'd0, match_o}, 16'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_check_string();
        t_random_frames();
        t_hold();
        t_start_only();
        t_start_with_byte();
        t_match();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule